// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block sits between a clocked host and an external asynchronous static RAM of 64K words by 16 bits. The RAM has one shared data bus and active-low chip select, write enable, output enable and one enable per byte lane. The host offers one word per handshake: a request with direction, address, write data and a byte-lane mask. The controller registers the address, the lane enables and every strobe. It holds them for a number of clock cycles derived from the RAM's timing numbers and the clock period. It then returns all strobes to their inactive level before it takes the next request.

Reads hold chip select and output enable low for the access window. At the last edge of that window the controller captures the bus and pulses a one-cycle read-valid to the host. A turnaround gap with the RAM's outputs disabled follows every read, so the controller's own drivers never meet the RAM's drivers on the bus. Writes drive the data bus and pull chip select and write enable low. Output enable stays high for the whole write, so the shorter write-pulse figure applies. The bus is split into separate in, out and drive-enable signals, and the tristate buffer sits outside the block.

Top module: `sram_ctl`

## Requirements
- R1: After reset and whenever the controller is idle, `req_ready` is 1, `ram_cs_n`, `ram_we_n`, `ram_oe_n` and every bit of `ram_be_n` are 1, `ram_dq_oe` is 0 and `rsp_valid` is 0.
- R2: A read accepted at clock edge E0 drives `ram_cs_n`=0, `ram_oe_n`=0 and `ram_we_n`=1 from E0 up to edge E0+RD_CYC. At that edge the bus is captured into `rsp_rdata` and `rsp_valid` is 1 for exactly one cycle.
- R3: Mask bit 0 selects data bits 7:0 and mask bit 1 selects bits 15:8 (`req_be`/`ram_be_n` index = lane). Each lane enable is driven low only when its mask bit is 1. A lane not selected in a read returns 0 in `rsp_rdata`.
- R4: A write accepted at E0 drives `ram_cs_n`=0, `ram_we_n`=0, `ram_dq_oe`=1 and the write data on `ram_dq_out` for WR_CYC cycles. `ram_oe_n` stays 1 throughout, and `req_ready` returns after edge E0+WR_CYC.
- R5: Only selected lanes are written. A write with mask 00 leaves the RAM word unchanged.
- R6: After a read, all strobes stay high for TA_CYC cycles before `req_ready` returns. `ram_dq_oe` is never 1 while `ram_oe_n` is 0, nor in the cycle after `ram_oe_n` was 0.
- R7: Wait counts are the ceiling of timing over CLK_NS, with a minimum of 1. RD_CYC uses the largest of read cycle time, address access time, output-enable access time and byte-enable access time. WR_CYC uses the larger of write pulse and data setup. TA_CYC uses the output-disable time.
- R8: `req_ready` is 1 only in idle. A request presented while `req_ready` is 0 is not taken and does not change `ram_addr`.
- R9: While `ram_cs_n` stays low, `ram_addr` and `ram_be_n` do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle, request accepted on this edge |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Word address |
| req_wdata | input | DW | Write data |
| req_be | input | DW/8 | Byte-lane mask, bit n = lane n |
| rsp_valid | output | 1 | One-cycle read data valid |
| rsp_rdata | output | DW | Read data, unselected lanes zero |
| ram_addr | output | AW | Registered RAM address |
| ram_cs_n | output | 1 | Chip select, active low |
| ram_we_n | output | 1 | Write enable, active low |
| ram_oe_n | output | 1 | Output enable, active low |
| ram_be_n | output | DW/8 | Lane enables, active low |
| ram_dq_out | output | DW | Data toward the RAM |
| ram_dq_in | input | DW | Data from the RAM |
| ram_dq_oe | output | 1 | Drive enable for the data bus |

## Verification
The bench runs with a 5 ns clock, so RD_CYC, WR_CYC and TA_CYC are 2, 2 and 1. Strobes, address and write data are due one edge after acceptance. Read data and `rsp_valid` are due RD_CYC edges after acceptance. Ready returns WR_CYC edges after a write and RD_CYC+TA_CYC edges after a read. The bench counts edges from the accepting edge and samples every output at the falling edge that follows the due edge. Its RAM model supplies valid data only after RD_CYC-1 edges of output enable, so an early capture reads a marker value. A monitor at every falling edge flags any bus drive that overlaps output enable or the cycle after it.

// File: rtl/sram_ctl_pkg.sv
`timescale 1ns/1ps
package sram_ctl_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_READ  = 2'd1,
      ST_WRITE = 2'd2,
      ST_TURN  = 2'd3
   } sram_st_e;

   function automatic int unsigned max2(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

   // ceiling of ns / clk, never below one cycle
   function automatic int unsigned wait_cycles(input int unsigned ns, input int unsigned clk_ns);
      int unsigned c;
      c = (ns + clk_ns - 1) / clk_ns;
      return (c == 0) ? 1 : c;
   endfunction

endpackage

// File: rtl/sram_ctl_wait.sv
`timescale 1ns/1ps
module sram_ctl_wait #(
   parameter int CW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   output logic          done
);
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load)
         cnt_q <= load_val;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign done = (cnt_q == '0);
endmodule

// File: rtl/sram_ctl_lane.sv
`timescale 1ns/1ps
module sram_ctl_lane (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       latch,
   input  logic       release_i,
   input  logic       capture,
   input  logic       sel,
   input  logic [7:0] wbyte,
   input  logic [7:0] din,
   output logic       be_n,
   output logic [7:0] dout,
   output logic [7:0] rbyte
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         be_n  <= 1'b1;
         dout  <= '0;
         rbyte <= '0;
      end else begin
         if (latch) begin
            be_n <= ~sel;
            dout <= wbyte;
         end else if (release_i) begin
            be_n <= 1'b1;
         end
         if (capture)
            rbyte <= be_n ? 8'h00 : din;
      end
   end
endmodule

// File: rtl/sram_ctl_seq.sv
`timescale 1ns/1ps
module sram_ctl_seq
   import sram_ctl_pkg::*;
#(
   parameter int RD_CYC = 1,
   parameter int WR_CYC = 1,
   parameter int TA_CYC = 1,
   parameter int CW     = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   input  logic          req_write,
   input  logic          done,
   output logic          req_ready,
   output logic          latch,
   output logic          release_o,
   output logic          capture,
   output logic          load,
   output logic [CW-1:0] load_val,
   output logic          cs_n,
   output logic          we_n,
   output logic          oe_n,
   output logic          dq_oe,
   output logic          rsp_valid
);
   localparam logic [CW-1:0] RD_LD = CW'(RD_CYC - 1);
   localparam logic [CW-1:0] WR_LD = CW'(WR_CYC - 1);
   localparam logic [CW-1:0] TA_LD = CW'(TA_CYC - 1);

   sram_st_e st_q, st_d;

   assign req_ready = (st_q == ST_IDLE);
   assign latch     = req_ready && req_valid;
   assign capture   = (st_q == ST_READ) && done;
   assign release_o = ((st_q == ST_READ) || (st_q == ST_WRITE)) && done;

   always_comb begin
      st_d     = st_q;
      load     = 1'b0;
      load_val = '0;
      unique case (st_q)
         ST_IDLE: if (req_valid) begin
            load     = 1'b1;
            load_val = req_write ? WR_LD : RD_LD;
            st_d     = req_write ? ST_WRITE : ST_READ;
         end
         ST_READ: if (done) begin
            load     = 1'b1;
            load_val = TA_LD;
            st_d     = ST_TURN;
         end
         ST_WRITE: if (done) st_d = ST_IDLE;
         ST_TURN:  if (done) st_d = ST_IDLE;
         default:  st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= ST_IDLE;
         cs_n      <= 1'b1;
         we_n      <= 1'b1;
         oe_n      <= 1'b1;
         dq_oe     <= 1'b0;
         rsp_valid <= 1'b0;
      end else begin
         st_q      <= st_d;
         rsp_valid <= capture;
         if (latch) begin
            cs_n  <= 1'b0;
            we_n  <= ~req_write;
            oe_n  <= req_write;
            dq_oe <= req_write;
         end else if (release_o) begin
            cs_n  <= 1'b1;
            we_n  <= 1'b1;
            oe_n  <= 1'b1;
            dq_oe <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/sram_ctl.sv
`timescale 1ns/1ps
module sram_ctl
   import sram_ctl_pkg::*;
#(
   parameter int AW     = 16,
   parameter int DW     = 16,
   parameter int CLK_NS = 10,
   parameter int T_RC   = 10,
   parameter int T_AA   = 10,
   parameter int T_OE   = 5,
   parameter int T_BA   = 5,
   parameter int T_WP   = 7,
   parameter int T_DW   = 5,
   parameter int T_HZ   = 5
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            req_valid,
   output logic            req_ready,
   input  logic            req_write,
   input  logic [AW-1:0]   req_addr,
   input  logic [DW-1:0]   req_wdata,
   input  logic [DW/8-1:0] req_be,
   output logic            rsp_valid,
   output logic [DW-1:0]   rsp_rdata,
   output logic [AW-1:0]   ram_addr,
   output logic            ram_cs_n,
   output logic            ram_we_n,
   output logic            ram_oe_n,
   output logic [DW/8-1:0] ram_be_n,
   output logic [DW-1:0]   ram_dq_out,
   input  logic [DW-1:0]   ram_dq_in,
   output logic            ram_dq_oe
);
   localparam int NB     = DW / 8;
   localparam int RD_CYC = int'(wait_cycles(max2(max2(T_RC, T_AA), max2(T_OE, T_BA)), CLK_NS));
   localparam int WR_CYC = int'(wait_cycles(max2(T_WP, T_DW), CLK_NS));
   localparam int TA_CYC = int'(wait_cycles(T_HZ, CLK_NS));
   localparam int CW     = $clog2(max2(max2(RD_CYC, WR_CYC), TA_CYC) + 1) + 1;

   generate
      if (DW % 8 != 0 || DW < 8) begin : g_bad_dw
         $error("sram_ctl: DW must be a positive multiple of 8");
      end
      if (CLK_NS < 1) begin : g_bad_clk
         $error("sram_ctl: CLK_NS must be at least 1");
      end
      if (AW < 1) begin : g_bad_aw
         $error("sram_ctl: AW must be at least 1");
      end
   endgenerate

   logic          latch, release_w, capture, load, done;
   logic [CW-1:0] load_val;

   sram_ctl_seq #(
      .RD_CYC(RD_CYC), .WR_CYC(WR_CYC), .TA_CYC(TA_CYC), .CW(CW)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_write (req_write),
      .done      (done),
      .req_ready (req_ready),
      .latch     (latch),
      .release_o (release_w),
      .capture   (capture),
      .load      (load),
      .load_val  (load_val),
      .cs_n      (ram_cs_n),
      .we_n      (ram_we_n),
      .oe_n      (ram_oe_n),
      .dq_oe     (ram_dq_oe),
      .rsp_valid (rsp_valid)
   );

   sram_ctl_wait #(.CW(CW)) u_wait (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load),
      .load_val (load_val),
      .done     (done)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ram_addr <= '0;
      else if (latch)
         ram_addr <= req_addr;
   end

   for (genvar i = 0; i < NB; i++) begin : g_lane
      sram_ctl_lane u_lane (
         .clk       (clk),
         .rst_n     (rst_n),
         .latch     (latch),
         .release_i (release_w),
         .capture   (capture),
         .sel       (req_be[i]),
         .wbyte     (req_wdata[8*i +: 8]),
         .din       (ram_dq_in[8*i +: 8]),
         .be_n      (ram_be_n[i]),
         .dout      (ram_dq_out[8*i +: 8]),
         .rbyte     (rsp_rdata[8*i +: 8])
      );
   end
endmodule

// File: rtl/sram_ctl_chk.sv
`timescale 1ns/1ps
module sram_ctl_chk #(
   parameter int AW = 16,
   parameter int DW = 16
) (
   input logic            clk,
   input logic            rst_n,
   input logic            req_ready,
   input logic            rsp_valid,
   input logic [AW-1:0]   ram_addr,
   input logic            ram_cs_n,
   input logic            ram_we_n,
   input logic            ram_oe_n,
   input logic [DW/8-1:0] ram_be_n,
   input logic            ram_dq_oe
);
   logic cs_low_q, oe_low_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_low_q <= 1'b0;
         oe_low_q <= 1'b0;
      end else begin
         cs_low_q <= !ram_cs_n;
         oe_low_q <= !ram_oe_n;
      end
   end

   // R1
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (ram_cs_n && ram_we_n && ram_oe_n && (&ram_be_n) && !ram_dq_oe));

   // R4
   write_oe_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ram_we_n |-> ram_oe_n);

   // R6
   drive_vs_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ram_dq_oe |-> (ram_oe_n && !oe_low_q));

   // R2
   rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);

   // R2
   rsp_after_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> (ram_cs_n && ram_oe_n));

   // R8
   busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ram_cs_n |-> !req_ready);

   // R9
   addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ram_cs_n && cs_low_q) |-> ($stable(ram_addr) && $stable(ram_be_n)));
endmodule

bind sram_ctl sram_ctl_chk #(.AW(AW), .DW(DW)) u_chk (.*);

// File: tb/sram_ctl_test.sv
`timescale 1ns/1ps
module sram_ctl_test;
   localparam int RD_CYC = 2;  // ceil(10/5)
   localparam int WR_CYC = 2;  // ceil(7/5)
   localparam int TA_CYC = 1;  // ceil(5/5)

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_write = 1'b0;
   logic [15:0] req_addr = '0, req_wdata = '0;
   logic [1:0]  req_be = '0;
   logic        req_ready, rsp_valid, ram_cs_n, ram_we_n, ram_oe_n, ram_dq_oe;
   logic [15:0] rsp_rdata, ram_addr, ram_dq_out, ram_dq_in;
   logic [1:0]  ram_be_n;

   int checks = 0, fails = 0;

   always #2.5 clk = ~clk;

   sram_ctl #(.CLK_NS(5)) uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
      .req_be(req_be), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
      .ram_addr(ram_addr), .ram_cs_n(ram_cs_n), .ram_we_n(ram_we_n),
      .ram_oe_n(ram_oe_n), .ram_be_n(ram_be_n), .ram_dq_out(ram_dq_out),
      .ram_dq_in(ram_dq_in), .ram_dq_oe(ram_dq_oe));

   // RAM model: data valid only after RD_CYC-1 edges of output enable
   logic [15:0] mem [256];
   int rd_age = 0;
   initial for (int i = 0; i < 256; i++) mem[i] = 16'h7E7E;

   always @(posedge clk) begin
      if (!ram_cs_n && !ram_oe_n) rd_age <= rd_age + 1;
      else rd_age <= 0;
      if (!ram_cs_n && !ram_we_n && ram_dq_oe) begin
         if (!ram_be_n[0]) mem[ram_addr[7:0]][7:0]  <= ram_dq_out[7:0];
         if (!ram_be_n[1]) mem[ram_addr[7:0]][15:8] <= ram_dq_out[15:8];
      end
   end

   for (genvar l = 0; l < 2; l++) begin : g_model
      assign ram_dq_in[8*l +: 8] =
         (!ram_cs_n && !ram_oe_n && !ram_be_n[l] && rd_age >= RD_CYC - 1)
            ? mem[ram_addr[7:0]][8*l +: 8] : 8'hA5;
   end

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   // R6 bus contention monitor
   logic oe_low_seen = 1'b0;
   always @(negedge clk) begin
      if (rst_n && ram_dq_oe)
         chk(ram_oe_n && !oe_low_seen, "R6 drive overlaps output enable",
             {30'd0, ram_oe_n, oe_low_seen}, 32'h2);
      oe_low_seen <= !ram_oe_n;
   end

   // Caller is at a falling edge; request is accepted at the next rising edge.
   task automatic run_op(input logic wr, input logic [15:0] a, input logic [15:0] d,
                         input logic [1:0] be, input logic [15:0] exp);
      int k;
      int rsp_k;
      logic [15:0] got;
      chk(req_ready, "R8 ready before request", {31'd0, req_ready}, 32'd1);
      req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      k = 0; rsp_k = -1; got = '0;
      chk({ram_cs_n, ram_we_n, ram_oe_n, ram_dq_oe} == {1'b0, ~wr, wr, wr},
          wr ? "R4 write strobes" : "R2 read strobes",
          {28'd0, ram_cs_n, ram_we_n, ram_oe_n, ram_dq_oe}, {28'd0, 1'b0, ~wr, wr, wr});
      chk(ram_be_n == ~be, "R3 lane enables", {30'd0, ram_be_n}, {30'd0, ~be});
      chk(ram_addr == a, "R9 address", {16'd0, ram_addr}, {16'd0, a});
      if (wr) chk(ram_dq_out == d, "R4 write data", {16'd0, ram_dq_out}, {16'd0, d});
      while (!req_ready && k < 20) begin
         @(negedge clk);
         k++;
         if (rsp_valid) begin rsp_k = k; got = rsp_rdata; end
         if (!wr && k == RD_CYC - 1)
            chk(!ram_cs_n && !ram_oe_n, "R2 held through access", {30'd0, ram_cs_n, ram_oe_n}, 32'd0);
         if (!wr && k == RD_CYC)
            chk(ram_cs_n && ram_oe_n && !ram_dq_oe, "R6 turnaround strobes",
                {29'd0, ram_cs_n, ram_oe_n, ram_dq_oe}, 32'h6);
      end
      if (wr) begin
         chk(k == WR_CYC, "R4 R7 write length", k, WR_CYC);
      end else begin
         chk(rsp_k == RD_CYC, "R2 R7 rsp_valid timing", rsp_k, RD_CYC);
         chk(got == exp, "R3 R5 read data", {16'd0, got}, {16'd0, exp});
         chk(k == RD_CYC + TA_CYC, "R6 R7 read plus turnaround", k, RD_CYC + TA_CYC);
      end
   endtask

   // {wr, addr, wdata, be, expected}
   localparam logic [50:0] VEC [11] = '{
      {1'b1, 16'h0010, 16'h1234, 2'b11, 16'h0000},
      {1'b1, 16'h0011, 16'hABCD, 2'b11, 16'h0000},
      {1'b0, 16'h0010, 16'h0000, 2'b11, 16'h1234},
      {1'b1, 16'h0010, 16'hFF77, 2'b01, 16'h0000},
      {1'b0, 16'h0010, 16'h0000, 2'b11, 16'h1277},
      {1'b1, 16'h0011, 16'h5599, 2'b10, 16'h0000},
      {1'b0, 16'h0011, 16'h0000, 2'b11, 16'h55CD},
      {1'b0, 16'h0011, 16'h0000, 2'b01, 16'h00CD},
      {1'b0, 16'h0010, 16'h0000, 2'b10, 16'h1200},
      {1'b1, 16'h0020, 16'h0000, 2'b00, 16'h0000},
      {1'b0, 16'h0020, 16'h0000, 2'b11, 16'h7E7E}
   };

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      summary();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(req_ready && ram_cs_n && ram_we_n && ram_oe_n && (&ram_be_n) && !ram_dq_oe && !rsp_valid,
          "R1 reset state", {25'd0, req_ready, ram_cs_n, ram_we_n, ram_oe_n, ram_be_n, ram_dq_oe},
          {25'd0, 7'b1111110});
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready && ram_cs_n && !ram_dq_oe, "R1 idle after reset",
          {29'd0, req_ready, ram_cs_n, ram_dq_oe}, 32'h6);

      foreach (VEC[i])
         run_op(VEC[i][50], VEC[i][49:34], VEC[i][33:18], VEC[i][17:16], VEC[i][15:0]);

      // R6 read immediately followed by write: run_op covers timing, monitor covers overlap
      run_op(1'b0, 16'h0011, 16'h0, 2'b11, 16'h55CD);
      run_op(1'b1, 16'h0030, 16'hBEEF, 2'b11, 16'h0);
      run_op(1'b0, 16'h0030, 16'h0, 2'b11, 16'hBEEF);

      // R8 request during busy is not taken
      req_valid = 1'b1; req_write = 1'b1; req_addr = 16'h0040; req_wdata = 16'h1111; req_be = 2'b11;
      @(posedge clk);
      @(negedge clk);
      req_addr = 16'h0041; req_wdata = 16'h2222;
      @(negedge clk);
      chk(ram_addr == 16'h0040 && ram_dq_out == 16'h1111, "R8 busy request ignored",
          {ram_addr, ram_dq_out}, {16'h0040, 16'h1111});
      req_valid = 1'b0;
      while (!req_ready) @(negedge clk);
      run_op(1'b0, 16'h0041, 16'h0, 2'b11, 16'h7E7E);
      run_op(1'b0, 16'h0040, 16'h0, 2'b11, 16'h1111);

      // R1 reset in the middle of a read
      req_valid = 1'b1; req_write = 1'b0; req_addr = 16'h0010; req_be = 2'b11;
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      rst_n = 1'b0;
      #1;
      chk(req_ready && ram_cs_n && ram_oe_n && (&ram_be_n) && !rsp_valid, "R1 reset mid-access",
          {27'd0, req_ready, ram_cs_n, ram_oe_n, ram_be_n}, {27'd0, 5'b11111});
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      run_op(1'b0, 16'h0010, 16'h0, 2'b01, 16'h0077);

      summary();
   end
endmodule